// File: doc/BRIEF.md
# Memory-Mapped Register Processor Core

A 12-bit processor core with no register file visible to software. The program counter, the two ALU inputs, the ALU result, two move pointers, a branch target, an immediate word and a status word each live at a fixed low address of one flat word-addressed memory. The core holds that memory itself. Instruction fetch, operand fetch and move-source reads are combinational, so every instruction retires on one rising clock edge. This includes the two-word loads and the memory-to-memory move.

While the core is held in reset, the surrounding system fills the memory image through a load port. After reset is released, the core idles for one edge and then executes one instruction per edge. A debug port reads any address combinationally at any time, including the low words that hold the architectural state.

Top module: `mmr_core`

## Requirements
- R1: While `rst_ni` is low, and after it is released, address 0x000 (the PC) reads 0x010. Every other word keeps its loaded value across reset.
- R2: Load-port writes take effect only while the core is not running. A load to address 0x000 never changes the PC, and a load issued while the core runs changes nothing.
- R3: Opcode 0x3, carried in instruction bits [3:0], adds word 0x001 to word 0x002 and writes the sum to 0x003. It writes status 0x008 with bit 1 set to the carry-out and bit 0 set to signed overflow, and all upper bits zero. The PC then advances by one.
- R4: Opcode 0x1 writes word 0x001 minus word 0x002 to 0x003, and opcode 0x2 writes word 0x002 minus word 0x001. In the status word, bit 1 is 1 when no borrow occurs and bit 0 flags signed overflow. The PC advances by one.
- R5: Opcodes 0x4, 0x5 and 0x6 write the OR, XOR and AND of words 0x001 and 0x002 to 0x003. They clear both status flags, and the PC advances by one.
- R6: Opcodes 0xA, 0xB and 0xC copy the word at PC+1 to 0x007, 0x005 and 0x004 respectively. The PC then advances by two.
- R7: Opcode 0x7 copies the word at the address held in 0x004 to the address held in 0x005, and the PC advances by one.
- R8: When opcode 0x7 targets address 0x000, the moved word becomes the next PC with no increment.
- R9: Opcode 0x9 loads the PC from word 0x006 when word 0x003 is zero. Otherwise it advances the PC by one.
- R10: Opcode 0x0 and the undefined opcodes 0x8, 0xD, 0xE and 0xF only advance the PC by one. Instruction bits [11:4] never affect execution.
- R11: The status word changes only on ALU opcodes 0x1 to 0x6, or when a move targets address 0x008.
- R12: On the first rising edge after reset release the PC holds. The instruction at 0x010 retires on the second edge, and one instruction retires on every edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the load window |
| load_we_i | input | 1 | Image write strobe |
| load_addr_i | input | ADDR_W | Image write address |
| load_data_i | input | WORD_W | Image write data |
| dbg_addr_i | input | ADDR_W | Debug read address |
| dbg_data_o | output | WORD_W | Combinational debug read data |

## Verification
The bench builds the core with its default 12-bit word, 12-bit address and the reset PC at 0x010. The full 4096-word array therefore lets moves, pointers and jumps land anywhere, including the low architectural words, address 0x000, and the PC wrapping at the top of memory. Random images are biased toward small words. This makes pointers into the low region, moves onto the PC and status word, and zero ALU results (and so taken branches) frequent, alongside a directed program for the flag corner cases.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'h0,
    OP_SUBA = 4'h1,
    OP_SUBB = 4'h2,
    OP_ADD  = 4'h3,
    OP_OR   = 4'h4,
    OP_XOR  = 4'h5,
    OP_AND  = 4'h6,
    OP_MOVE = 4'h7,
    OP_BRCH = 4'h9,
    OP_LDIM = 4'hA,
    OP_LDDP = 4'hB,
    OP_LDSP = 4'hC
  } op_e;

  // fixed architectural word addresses
  localparam int unsigned A_PC   = 0;
  localparam int unsigned A_OPA  = 1;
  localparam int unsigned A_OPB  = 2;
  localparam int unsigned A_DEST = 3;
  localparam int unsigned A_SRCP = 4;
  localparam int unsigned A_DSTP = 5;
  localparam int unsigned A_JMP  = 6;
  localparam int unsigned A_IMM  = 7;
  localparam int unsigned A_STAT = 8;
  localparam int unsigned NUM_LOW = 9;
  localparam int unsigned IW = $clog2(NUM_LOW);

  localparam int unsigned FLG_OV = 0;
  localparam int unsigned FLG_CY = 1;

endpackage

// File: rtl/mmr_alu.sv
module mmr_alu #(
  parameter int unsigned W = 12
) (
  input  logic [2:0]   fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ov_o
);
  logic         sub;
  logic [W-1:0] x, y, yy;
  logic [W:0]   sum;

  always_comb begin
    sub = (fn_i == 3'd1) || (fn_i == 3'd2);
    x   = (fn_i == 3'd2) ? b_i : a_i;
    y   = (fn_i == 3'd2) ? a_i : b_i;
    yy  = sub ? ~y : y;
    sum = {1'b0, x} + {1'b0, yy} + (W+1)'(sub);
    res_o = sum[W-1:0];
    cy_o  = sum[W];
    ov_o  = (x[W-1] == yy[W-1]) && (sum[W-1] != x[W-1]);
    unique case (fn_i)
      3'd4: begin res_o = a_i | b_i; cy_o = 1'b0; ov_o = 1'b0; end
      3'd5: begin res_o = a_i ^ b_i; cy_o = 1'b0; ov_o = 1'b0; end
      3'd6: begin res_o = a_i & b_i; cy_o = 1'b0; ov_o = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/mmr_ram.sv
module mmr_ram #(
  parameter int unsigned AW   = 12,
  parameter int unsigned W    = 12,
  parameter int unsigned N_RD = 4
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [N_RD-1:0][AW-1:0]  raddr_i,
  output logic [N_RD-1:0][W-1:0]   rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    assign rdata_o[k] = mem[raddr_i[k]];
  end
endmodule

// File: rtl/mmr_lowfile.sv
module mmr_lowfile import mmr_pkg::*; #(
  parameter int unsigned W        = 12,
  parameter logic [W-1:0] RESET_PC = W'(16)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pc_en_i,
  input  logic [W-1:0]               pc_next_i,
  input  logic                       wr_en_i,
  input  logic [IW-1:0]              wr_idx_i,
  input  logic [W-1:0]               wr_data_i,
  input  logic                       alu_en_i,
  input  logic [W-1:0]               alu_res_i,
  input  logic [W-1:0]               alu_stat_i,
  output logic [NUM_LOW-1:0][W-1:0]  regs_o
);
  logic [W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= RESET_PC;
    else if (pc_en_i) pc_q <= pc_next_i;
  end
  assign regs_o[A_PC] = pc_q;

  // index 0 is never written through the general port
  for (genvar i = 1; i < NUM_LOW; i++) begin : g_word
    logic [W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (alu_en_i && (i == A_DEST))                q <= alu_res_i;
      else if (alu_en_i && (i == A_STAT))           q <= alu_stat_i;
      else if (wr_en_i && (wr_idx_i == IW'(i)))     q <= wr_data_i;
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/mmr_core.sv
module mmr_core import mmr_pkg::*; #(
  parameter int unsigned   WORD_W   = 12,
  parameter int unsigned   ADDR_W   = 12,
  parameter logic [WORD_W-1:0] RESET_PC = WORD_W'(16)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [WORD_W-1:0] dbg_data_o
);
  localparam int unsigned N_RD = 4;
  localparam int unsigned RP_INS = 0, RP_OPN = 1, RP_SRC = 2, RP_DBG = 3;
  localparam logic [ADDR_W-1:0] LOW_LIM = ADDR_W'(NUM_LOW);

  logic                            run_q;
  logic [NUM_LOW-1:0][WORD_W-1:0]  low_q;
  logic [N_RD-1:0][ADDR_W-1:0]     rd_addr;
  logic [N_RD-1:0][WORD_W-1:0]     ram_rd, rd_val;

  logic [WORD_W-1:0] pc_w, op1_w, op2_w, dest_w, ptr1_w, ptr2_w, ptr3_w, stat_w;
  logic [WORD_W-1:0] instr_w, opnd_w, mv_data_w, pc_next;
  logic [3:0]        op_w;
  logic              unused_hi;

  logic              dec_wr, dec_alu;
  logic [ADDR_W-1:0] dec_addr;
  logic [WORD_W-1:0] dec_data;

  logic              w_en, low_we, ram_we;
  logic [ADDR_W-1:0] w_addr;
  logic [WORD_W-1:0] w_data;

  logic [WORD_W-1:0] alu_res;
  logic              alu_cy, alu_ov;

  // holds fetch off for one edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  assign pc_w   = low_q[A_PC];
  assign op1_w  = low_q[A_OPA];
  assign op2_w  = low_q[A_OPB];
  assign dest_w = low_q[A_DEST];
  assign ptr1_w = low_q[A_SRCP];
  assign ptr2_w = low_q[A_DSTP];
  assign ptr3_w = low_q[A_JMP];
  assign stat_w = low_q[A_STAT];

  assign rd_addr[RP_INS] = pc_w[ADDR_W-1:0];
  assign rd_addr[RP_OPN] = pc_w[ADDR_W-1:0] + ADDR_W'(1);
  assign rd_addr[RP_SRC] = ptr1_w[ADDR_W-1:0];
  assign rd_addr[RP_DBG] = dbg_addr_i;

  for (genvar k = 0; k < N_RD; k++) begin : g_rmux
    assign rd_val[k] = (rd_addr[k] < LOW_LIM) ? low_q[rd_addr[k][IW-1:0]] : ram_rd[k];
  end

  assign instr_w    = rd_val[RP_INS];
  assign opnd_w     = rd_val[RP_OPN];
  assign mv_data_w  = rd_val[RP_SRC];
  assign dbg_data_o = rd_val[RP_DBG];
  assign op_w       = instr_w[3:0];
  assign unused_hi  = ^instr_w[WORD_W-1:4];

  mmr_alu #(.W(WORD_W)) u_alu (
    .fn_i (op_w[2:0]),
    .a_i  (op1_w),
    .b_i  (op2_w),
    .res_o(alu_res),
    .cy_o (alu_cy),
    .ov_o (alu_ov)
  );

  always_comb begin
    pc_next  = pc_w + WORD_W'(1);
    dec_wr   = 1'b0;
    dec_alu  = 1'b0;
    dec_addr = '0;
    dec_data = '0;
    case (op_w)
      OP_SUBA, OP_SUBB, OP_ADD, OP_OR, OP_XOR, OP_AND: dec_alu = 1'b1;
      OP_MOVE: begin
        if (ptr2_w[ADDR_W-1:0] == ADDR_W'(A_PC)) begin
          pc_next = mv_data_w;
        end else begin
          dec_wr   = 1'b1;
          dec_addr = ptr2_w[ADDR_W-1:0];
          dec_data = mv_data_w;
        end
      end
      OP_BRCH: if (dest_w == '0) pc_next = ptr3_w;
      OP_LDIM, OP_LDDP, OP_LDSP: begin
        dec_wr   = 1'b1;
        dec_data = opnd_w;
        pc_next  = pc_w + WORD_W'(2);
        dec_addr = (op_w == OP_LDIM) ? ADDR_W'(A_IMM) :
                   (op_w == OP_LDDP) ? ADDR_W'(A_DSTP) : ADDR_W'(A_SRCP);
      end
      default: ;
    endcase
  end

  // load port owns the write path until the core runs
  assign w_en   = run_q ? dec_wr   : load_we_i;
  assign w_addr = run_q ? dec_addr : load_addr_i;
  assign w_data = run_q ? dec_data : load_data_i;
  assign low_we = w_en && (w_addr < LOW_LIM);
  assign ram_we = w_en && !(w_addr < LOW_LIM);

  mmr_lowfile #(.W(WORD_W), .RESET_PC(RESET_PC)) u_low (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_en_i   (run_q),
    .pc_next_i (pc_next),
    .wr_en_i   (low_we),
    .wr_idx_i  (w_addr[IW-1:0]),
    .wr_data_i (w_data),
    .alu_en_i  (run_q && dec_alu),
    .alu_res_i (alu_res),
    .alu_stat_i({{(WORD_W-2){1'b0}}, alu_cy, alu_ov}),
    .regs_o    (low_q)
  );

  mmr_ram #(.AW(ADDR_W), .W(WORD_W), .N_RD(N_RD)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(w_addr),
    .wdata_i(w_data),
    .raddr_i(rd_addr),
    .rdata_o(ram_rd)
  );
endmodule

// File: rtl/mmr_core_chk.sv
module mmr_core_chk #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_q,
  input logic [3:0]        op,
  input logic [WORD_W-1:0] pc,
  input logic [WORD_W-1:0] op1,
  input logic [WORD_W-1:0] op2,
  input logic [WORD_W-1:0] dest,
  input logic [WORD_W-1:0] ptr2,
  input logic [WORD_W-1:0] ptr3,
  input logic [WORD_W-1:0] stat,
  input logic [WORD_W-1:0] mv_data
);
  logic is_alu, is_logic, is_load, mv_pc, mv_stat;
  assign is_alu   = (op >= 4'h1) && (op <= 4'h6);
  assign is_logic = (op >= 4'h4) && (op <= 4'h6);
  assign is_load  = (op >= 4'hA) && (op <= 4'hC);
  assign mv_pc    = (op == 4'h7) && (ptr2[ADDR_W-1:0] == '0);
  assign mv_stat  = (op == 4'h7) && (ptr2[ADDR_W-1:0] == ADDR_W'(8));

  p_add_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (op == 4'h3) |=> dest == $past(op1 + op2));

  p_alu_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && is_alu |=> pc == $past(pc) + WORD_W'(1));

  p_logic_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && is_logic |=> stat[1:0] == 2'b00);

  p_load_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && is_load |=> pc == $past(pc) + WORD_W'(2));

  p_move_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && mv_pc |=> pc == $past(mv_data));

  p_brch_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && (op == 4'h9) && (dest == '0) |=> pc == $past(ptr3));

  p_stat_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !is_alu && !mv_stat |=> $stable(stat));

  p_idle_edge_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> $stable(pc));
endmodule

bind mmr_core mmr_core_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_q  (run_q),
  .op     (op_w),
  .pc     (pc_w),
  .op1    (op1_w),
  .op2    (op2_w),
  .dest   (dest_w),
  .ptr2   (ptr2_w),
  .ptr3   (ptr3_w),
  .stat   (stat_w),
  .mv_data(mv_data_w)
);

// File: tb/sim_mmr_core.sv
`timescale 1ns/100ps
module sim_mmr_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_we = 1'b0;
  logic [11:0] load_addr = '0, load_data = '0, dbg_addr = '0;
  logic [11:0] dbg_data;
  int checks = 0, fails = 0;
  logic [11:0] m [4096];

  always #2 clk = ~clk;

  mmr_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .load_we_i(load_we), .load_addr_i(load_addr),
    .load_data_i(load_data), .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%03h exp=%03h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic peek(input logic [11:0] a, output logic [11:0] d);
    dbg_addr = a;
    #0.1;
    d = dbg_data;
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic [11:0] dst);
    case (op)
      4'h1, 4'h2:       return "R4";
      4'h3:             return "R3";
      4'h4, 4'h5, 4'h6: return "R5";
      4'h7:             return (dst == 0) ? "R8" : "R7";
      4'h9:             return "R9";
      4'hA, 4'hB, 4'hC: return "R6";
      default:          return "R10";
    endcase
  endfunction

  // reference step written from the requirements
  task automatic model_step(output logic [3:0] op, output int wa);
    logic [11:0] pc, a, b, r, v;
    logic [12:0] s;
    logic cy, ov;
    pc = m[0];
    op = m[pc][3:0];
    wa = -1;
    case (op)
      4'h1, 4'h2, 4'h3: begin
        a = (op == 4'h2) ? m[2] : m[1];
        b = (op == 4'h2) ? m[1] : m[2];
        if (op == 4'h3) begin
          s  = {1'b0, a} + {1'b0, b};
          r  = s[11:0];
          ov = (a[11] == b[11]) && (r[11] != a[11]);
        end else begin
          s  = {1'b0, a} + {1'b0, ~b} + 13'd1;
          r  = s[11:0];
          ov = (a[11] != b[11]) && (r[11] != a[11]);
        end
        cy = s[12];
        m[3] = r; m[8] = {10'b0, cy, ov}; m[0] = pc + 12'd1;
      end
      4'h4, 4'h5, 4'h6: begin
        m[3] = (op == 4'h4) ? (m[1] | m[2]) : (op == 4'h5) ? (m[1] ^ m[2]) : (m[1] & m[2]);
        m[8] = 12'h000; m[0] = pc + 12'd1;
      end
      4'h7: begin
        v = m[m[4]];
        if (m[5] == 12'h000) m[0] = v;
        else begin wa = int'(m[5]); m[m[5]] = v; m[0] = pc + 12'd1; end
      end
      4'h9: m[0] = (m[3] == 12'h000) ? m[6] : pc + 12'd1;
      4'hA, 4'hB, 4'hC: begin
        v = m[pc + 12'd1];
        if (op == 4'hA) m[7] = v; else if (op == 4'hB) m[5] = v; else m[4] = v;
        m[0] = pc + 12'd2;
      end
      default: m[0] = pc + 12'd1;
    endcase
  endtask

  task automatic compare(input string tag, input logic [3:0] op, input int wa);
    logic [11:0] d;
    for (int a = 0; a < 9; a++) begin
      peek(12'(a), d);
      if (a == 8 && !(op >= 4'h1 && op <= 4'h6)) chk("R11 status", d, m[8]);
      else chk(tag, d, m[a]);
    end
    if (wa > 8) begin
      peek(12'(wa), d);
      chk(tag, d, m[wa]);
    end
  endtask

  task automatic run_image(input int steps, input bit directed);
    logic [11:0] d, pcb, dstb;
    logic [3:0] op;
    int wa;
    @(negedge clk) rst_ni = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      load_we = 1'b1; load_addr = 12'(a); load_data = m[a];
    end
    @(negedge clk);
    load_we = 1'b0;
    peek(12'h000, d); chk("R1 reset pc (R2 load to 0 ignored)", d, 12'h010);
    rst_ni = 1'b1;
    m[0] = 12'h010;
    @(negedge clk);
    peek(12'h000, d); chk("R12 pc holds first edge", d, 12'h010);
    peek(12'h002, d); chk("R1 low word kept", d, m[2]);
    peek(12'h101, d); chk("R1 ram word kept", d, m[12'h101]);
    for (int i = 0; i < steps; i++) begin
      if (directed && i == 25) begin
        load_we = 1'b1; load_addr = 12'h100; load_data = 12'h123;
      end
      pcb = m[0]; dstb = m[5];
      @(posedge clk);
      model_step(op, wa);
      @(negedge clk);
      load_we = 1'b0;
      compare(tag_of(op, dstb), op, wa);
      if (directed) begin
        case (pcb)
          12'h010: begin peek(3, d); chk("R3 add ovf dest", d, 12'h800);
                         peek(8, d); chk("R3 add ovf stat", d, 12'h001); end
          12'h011: begin peek(3, d); chk("R4 sub1 dest", d, 12'h7FE);
                         peek(8, d); chk("R4 sub1 no-borrow stat", d, 12'h002); end
          12'h012: begin peek(3, d); chk("R5 and dest", d, 12'h001);
                         peek(8, d); chk("R5 and clears flags", d, 12'h000); end
          12'h013: begin peek(3, d); chk("R4 sub2 borrow dest", d, 12'h802);
                         peek(8, d); chk("R4 sub2 borrow stat", d, 12'h000); end
          12'h014: begin peek(7, d); chk("R6 imm", d, 12'hABC);
                         peek(0, d); chk("R6 pc+2", d, 12'h016); end
          12'h01A: begin peek(12'h100, d); chk("R7 move", d, 12'hABC); end
          12'h01B: begin peek(0, d); chk("R9 not taken", d, 12'h01C); end
          12'h01C: begin peek(0, d); chk("R10 undefined op", d, 12'h01D); end
          12'h023: begin peek(0, d); chk("R9 taken", d, 12'h040); end
          12'h044: begin peek(0, d); chk("R8 move to pc", d, 12'h080); end
          default: ;
        endcase
      end
    end
    if (directed) begin
      peek(12'h100, d); chk("R2 load while running ignored", d, 12'hABC);
    end
  endtask

  function automatic logic [11:0] rword();
    if ($urandom % 4 == 0) return 12'($urandom % 16);
    return 12'($urandom);
  endfunction

  task automatic put(input logic [11:0] a, input logic [11:0] v);
    m[a] = v;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int a = 0; a < 4096; a++) m[a] = 12'h000;
    put(12'h000, 12'h3FF); put(12'h001, 12'h7FF); put(12'h002, 12'h001);
    put(12'h003, 12'h555); put(12'h006, 12'h040);
    put(12'h101, 12'h001); put(12'h102, 12'h080);
    put(12'h010, 12'h003); put(12'h011, 12'hF21); put(12'h012, 12'h006);
    put(12'h013, 12'h002); put(12'h014, 12'h00A); put(12'h015, 12'hABC);
    put(12'h016, 12'h00C); put(12'h017, 12'h007); put(12'h018, 12'h00B);
    put(12'h019, 12'h100); put(12'h01A, 12'h007); put(12'h01B, 12'h009);
    put(12'h01C, 12'h00E); put(12'h01D, 12'h00C); put(12'h01E, 12'h101);
    put(12'h01F, 12'h00B); put(12'h020, 12'h001); put(12'h021, 12'h007);
    put(12'h022, 12'h005); put(12'h023, 12'h009);
    put(12'h040, 12'h00C); put(12'h041, 12'h102); put(12'h042, 12'h00B);
    put(12'h043, 12'h000); put(12'h044, 12'h007); put(12'h080, 12'h008);
    run_image(30, 1'b1);
    for (int img = 0; img < 3; img++) begin
      for (int a = 0; a < 4096; a++) m[a] = rword();
      run_image(400, 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule